// File: doc/BRIEF.md
# Byte-Command Sound Register Decoder

This block sits between an 8-bit parallel write bus and the tone, noise and volume logic of a four-channel sound generator. It turns each byte written on the bus into an update of one register: three 10-bit tone periods, a 3-bit noise control word and four 4-bit attenuation levels. All register contents are exposed as flat output vectors for the sound logic to use. Tone generation and mixing are done elsewhere.

Command bytes carry bit 7 set. They name a channel and a register kind, and the block remembers that choice. A later byte with bit 7 clear carries six more period bits, and these go to the tone channel named most recently. A full period therefore takes two writes: a command byte with the low four bits, then a data byte with the upper six.

A write is taken on the falling edge of the active-low write enable. It takes effect in a single clock, so the bus never has to wait. A noise-control write also asks for a one-cycle restart pulse. The pulse follows once write enable has gone high again.

Top module: `byteCmdRegs`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears all three tone periods and the noise control to 0 and sets all four attenuations to 15. The remembered target becomes channel 0, kind tone.
- R2: A byte with bit7=1, bit4=0 and bits[6:5]=c, where c is 0..2, loads bits[3:0] of the period of tone channel c. Bits [9:4] of that period keep their value. The channel and kind are remembered.
- R3: A byte with bits[7:6]=00 loads bits[5:0] into bits[9:4] of the period of the remembered tone channel. Repeated data bytes keep going to that same channel. The sequence 0x8C, 0x11 gives channel 0 the period 0x11C.
- R4: A byte with bit7=1 and bit4=1 loads bits[3:0] into the attenuation of channel bits[6:5]. Channel 3 is the noise channel. The value 0 means full volume and 15 means silent.
- R5: A byte with bits[7:4]=1110 loads bits[2:0] into the noise control. Bit 2 selects the noise type and bits[1:0] select the rate. The remembered target becomes channel 3.
- R6: A data byte changes nothing in three cases: the last command byte was an attenuation write, the last command byte was a noise write, or bit 6 of the data byte is 1.
- R7: Only the byte present at the first clock edge with write enable low is used. Holding write enable low for more cycles, even while the bus changes, causes no further write.
- R8: After a noise-control write, noiseRestart is high for exactly one cycle. It rises after the first clock edge at which write enable is sampled high again. It stays low for all other writes and for as long as write enable is held low.
- R9: A register change is visible on the outputs right after the clock edge at which write enable is first sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| weN | input | 1 | Write enable, active low |
| dataIn | input | 8 | Command or data byte |
| tonePeriods | output | 30 | Tone periods, channel i at bits [10i+9:10i] |
| noiseCtrl | output | 3 | Noise type (bit 2) and rate (bits 1:0) |
| attenLevels | output | 16 | Attenuations, channel i at bits [4i+3:4i] |
| noiseRestart | output | 1 | One-cycle noise restart request |

## Verification
If the remembered channel or kind is wrong, nothing shows at once. The fault appears only at the next data byte, when the upper period bits land in the wrong tone channel or a data byte that should be dropped changes something. For this reason the bench sends data bytes after every kind of command byte. If the edge detector misses a write or takes one twice, the outputs are wrong on the cycle after the write edge. If the restart flag is stuck, the pulse is missing, comes too early or repeats on the cycles around the release of write enable. Each of these is sampled cycle by cycle.

// File: rtl/byteCmdPkg.sv
package byteCmdPkg;
  typedef enum logic { KIND_TONE = 1'b0, KIND_ATTEN = 1'b1 } latchKindT;

  typedef struct packed {
    logic       loadLow;
    logic       loadHigh;
    logic       loadNoise;
    logic       loadAtten;
    logic [1:0] chan;
    logic [5:0] payload;
  } strobeT;
endpackage

// File: rtl/cmdCtrl.sv
module cmdCtrl
  import byteCmdPkg::*;
#(
  parameter int NUM_TONE = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       weN,
  input  logic [7:0] dataIn,
  output strobeT     stb,
  output logic       restartPulse
);
  localparam logic [1:0] LAST_TONE = 2'(NUM_TONE - 1);

  logic      weNDly;
  logic      writeEdge;
  logic [1:0] latchChan;
  latchKindT latchKind;
  logic      restartPending;

  assign writeEdge = !weN && weNDly;

  always_comb begin
    stb         = '0;
    stb.chan    = dataIn[6:5];
    stb.payload = dataIn[5:0];
    if (writeEdge) begin
      if (dataIn[7]) begin
        if (dataIn[4])               stb.loadAtten = 1'b1;
        else if (dataIn[6:5] == 2'd3) stb.loadNoise = 1'b1;
        else                         stb.loadLow   = 1'b1;
      end else if (!dataIn[6] && latchKind == KIND_TONE && latchChan <= LAST_TONE) begin
        stb.loadHigh = 1'b1;
        stb.chan     = latchChan;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      weNDly         <= 1'b1;
      latchChan      <= 2'd0;
      latchKind      <= KIND_TONE;
      restartPending <= 1'b0;
      restartPulse   <= 1'b0;
    end else begin
      weNDly       <= weN;
      restartPulse <= 1'b0;
      if (writeEdge && dataIn[7]) begin
        latchChan <= dataIn[6:5];
        latchKind <= latchKindT'(dataIn[4]);
      end
      if (stb.loadNoise) begin
        restartPending <= 1'b1;
      end else if (weN && restartPending) begin
        restartPending <= 1'b0;
        restartPulse   <= 1'b1;
      end
    end
  end

  // R7: a held-low write enable never produces a second load
  assert_one_write_per_low_R7: assert property (@(posedge clk) disable iff (rst)
    (!weN && $past(!weN)) |-> !(stb.loadLow || stb.loadHigh || stb.loadNoise || stb.loadAtten));

  // R8: restart only follows a cycle with write enable high
  assert_restart_after_release_R8: assert property (@(posedge clk) disable iff (rst)
    restartPulse |-> $past(weN));

  // R8: restart lasts a single cycle
  assert_restart_single_R8: assert property (@(posedge clk) disable iff (rst)
    restartPulse |=> !restartPulse);
endmodule

// File: rtl/regFile.sv
module regFile
  import byteCmdPkg::*;
#(
  parameter int NUM_TONE = 3,
  parameter int NUM_CHAN = 4,
  parameter int PERIOD_W = 10,
  parameter int LOW_W    = 4,
  parameter int ATTEN_W  = 4,
  parameter int NOISE_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  strobeT                       stb,
  output logic [NUM_TONE*PERIOD_W-1:0] tonePeriods,
  output logic [NOISE_W-1:0]           noiseCtrl,
  output logic [NUM_CHAN*ATTEN_W-1:0]  attenLevels
);
  localparam int HIGH_W = PERIOD_W - LOW_W;

  for (genvar g = 0; g < NUM_TONE; g++) begin : gTone
    always_ff @(posedge clk) begin
      if (rst) begin
        tonePeriods[g*PERIOD_W +: PERIOD_W] <= '0;
      end else begin
        if (stb.loadLow && stb.chan == 2'(g))
          tonePeriods[g*PERIOD_W +: LOW_W] <= stb.payload[LOW_W-1:0];
        if (stb.loadHigh && stb.chan == 2'(g))
          tonePeriods[g*PERIOD_W+LOW_W +: HIGH_W] <= stb.payload[HIGH_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_CHAN; g++) begin : gAtten
    always_ff @(posedge clk) begin
      if (rst)
        attenLevels[g*ATTEN_W +: ATTEN_W] <= '1;
      else if (stb.loadAtten && stb.chan == 2'(g))
        attenLevels[g*ATTEN_W +: ATTEN_W] <= stb.payload[ATTEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                noiseCtrl <= '0;
    else if (stb.loadNoise) noiseCtrl <= stb.payload[NOISE_W-1:0];
  end

  // R2/R3: periods move only on a tone load strobe
  assert_tone_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(stb.loadLow || stb.loadHigh) |=> $stable(tonePeriods));

  // R4: attenuations move only on an attenuation load strobe
  assert_atten_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !stb.loadAtten |=> $stable(attenLevels));

  // R5: noise control moves only on a noise load strobe
  assert_noise_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !stb.loadNoise |=> $stable(noiseCtrl));
endmodule

// File: rtl/byteCmdRegs.sv
module byteCmdRegs
  import byteCmdPkg::*;
#(
  parameter int NUM_TONE = 3,
  parameter int NUM_CHAN = 4,
  parameter int PERIOD_W = 10,
  parameter int LOW_W    = 4,
  parameter int ATTEN_W  = 4,
  parameter int NOISE_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         weN,
  input  logic [7:0]                   dataIn,
  output logic [NUM_TONE*PERIOD_W-1:0] tonePeriods,
  output logic [NOISE_W-1:0]           noiseCtrl,
  output logic [NUM_CHAN*ATTEN_W-1:0]  attenLevels,
  output logic                         noiseRestart
);
  strobeT stb;

  cmdCtrl #(.NUM_TONE(NUM_TONE)) uCtrl (
    .clk(clk), .rst(rst), .weN(weN), .dataIn(dataIn),
    .stb(stb), .restartPulse(noiseRestart)
  );

  regFile #(
    .NUM_TONE(NUM_TONE), .NUM_CHAN(NUM_CHAN), .PERIOD_W(PERIOD_W),
    .LOW_W(LOW_W), .ATTEN_W(ATTEN_W), .NOISE_W(NOISE_W)
  ) uRegs (
    .clk(clk), .rst(rst), .stb(stb),
    .tonePeriods(tonePeriods), .noiseCtrl(noiseCtrl), .attenLevels(attenLevels)
  );
endmodule

// File: tb/byteCmdRegs_test.sv
module byteCmdRegs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        weN = 1'b1;
  logic [7:0]  dataIn = 8'h00;
  logic [29:0] tonePeriods;
  logic [2:0]  noiseCtrl;
  logic [15:0] attenLevels;
  logic        noiseRestart;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [29:0] tone;
    logic [2:0]  noise;
    logic [15:0] atten;
    string       tag;
  } expT;
  expT expQ[$];

  logic [9:0] mTone[3];
  logic [2:0] mNoise;
  logic [3:0] mAtten[4];
  int         mChan;
  bit         mAttenKind;
  bit         mNoiseHit;

  byteCmdRegs uut (
    .clk(clk), .rst(rst), .weN(weN), .dataIn(dataIn),
    .tonePeriods(tonePeriods), .noiseCtrl(noiseCtrl),
    .attenLevels(attenLevels), .noiseRestart(noiseRestart)
  );

  always #10 clk = ~clk;

  function automatic void modelByte(input logic [7:0] b);
    mNoiseHit = 1'b0;
    if (b[7]) begin
      mChan = int'(b[6:5]);
      mAttenKind = b[4];
      if (b[4]) mAtten[mChan] = b[3:0];
      else if (mChan == 3) begin mNoise = b[2:0]; mNoiseHit = 1'b1; end
      else mTone[mChan][3:0] = b[3:0];
    end else if (!b[6] && !mAttenKind && mChan < 3) begin
      mTone[mChan][9:4] = b[5:0];
    end
  endfunction

  function automatic void pushExp(input string tag);
    expT e;
    for (int i = 0; i < 3; i++) e.tone[i*10 +: 10] = mTone[i];
    for (int i = 0; i < 4; i++) e.atten[i*4 +: 4] = mAtten[i];
    e.noise = mNoise;
    e.tag = tag;
    expQ.push_back(e);
  endfunction

  task automatic checkBit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s noiseRestart actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Monitor: pops expected state and compares, off the active edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        expT e;
        e = expQ.pop_front();
        checks++;
        if (tonePeriods !== e.tone || noiseCtrl !== e.noise || attenLevels !== e.atten) begin
          fails++;
          $display("FAIL %s actual tone=%h noise=%h atten=%h expected tone=%h noise=%h atten=%h",
                   e.tag, tonePeriods, noiseCtrl, attenLevels, e.tone, e.noise, e.atten);
        end
      end
    end
  end

  // Driver: one write, held low for hold cycles, bus changed to b2 after the first edge
  task automatic wr(input logic [7:0] b, input int hold, input logic [7:0] b2, input string tag);
    bit isNoise;
    @(negedge clk);
    weN = 1'b0;
    dataIn = b;
    modelByte(b);
    isNoise = mNoiseHit;
    pushExp({tag, " R9"});
    for (int i = 0; i < hold; i++) begin
      @(posedge clk);
      #5;
      checkBit(noiseRestart, 1'b0, "R8 held low");
      @(negedge clk);
      dataIn = b2;
    end
    weN = 1'b1;
    pushExp({tag, " R7 after release"});
    @(posedge clk);
    #5;
    checkBit(noiseRestart, isNoise, "R8 pulse");
    @(posedge clk);
    #5;
    checkBit(noiseRestart, 1'b0, "R8 single");
  endtask

  initial begin
    for (int i = 0; i < 3; i++) mTone[i] = '0;
    for (int i = 0; i < 4; i++) mAtten[i] = 4'hF;
    mNoise = '0;
    mChan = 0;
    mAttenKind = 1'b0;
    mNoiseHit = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    pushExp("R1 reset state");
    @(posedge clk);
    #5;
    checkBit(noiseRestart, 1'b0, "R1 restart low");

    wr(8'h8C, 1, 8'h8C, "R2 low ch0");
    wr(8'h11, 1, 8'h11, "R3 high ch0 0x11C");
    wr(8'hAF, 1, 8'hAF, "R2 low ch1");
    wr(8'h3F, 1, 8'h3F, "R3 high ch1");
    wr(8'hC5, 1, 8'hC5, "R2 low ch2");
    wr(8'h2A, 1, 8'h2A, "R3 high ch2");
    wr(8'h15, 1, 8'h15, "R3 repeat ch2");
    wr(8'h90, 1, 8'h90, "R4 atten ch0 loud");
    wr(8'hBF, 1, 8'hBF, "R4 atten ch1");
    wr(8'hD7, 1, 8'hD7, "R4 atten ch2");
    wr(8'hF8, 1, 8'hF8, "R4 atten ch3");
    wr(8'h05, 1, 8'h05, "R6 data after atten");
    wr(8'hE6, 1, 8'hE6, "R5 noise");
    wr(8'h3F, 1, 8'h3F, "R6 data after noise");
    wr(8'h83, 1, 8'h83, "R2 low ch0 again");
    wr(8'h7F, 1, 8'h7F, "R6 bit6 data");
    wr(8'h84, 3, 8'hB2, "R7 held with bus change");
    wr(8'hE3, 4, 8'hE3, "R8 long noise hold");
    wr(8'h22, 2, 8'h01, "R7 held data byte ignored");

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) mTone[i] = '0;
    for (int i = 0; i < 4; i++) mAtten[i] = 4'hF;
    mNoise = '0;
    mChan = 0;
    mAttenKind = 1'b0;
    pushExp("R1 second reset");
    wr(8'h09, 1, 8'h09, "R1 target is tone ch0 after reset");

    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule